// File: doc/BRIEF.md
# Cascaded Two-Stage Priority Interrupt Controller

This block gathers sixteen interrupt lines into a single request to a processor. It is built from two identical eight-input controller stages. The primary stage serves lines 0 to 7. The secondary stage serves lines 8 to 15, and its request output feeds primary input 2 in place of line 2. Software programs each stage over a byte-wide write bus. A command write starts a setup sequence, and the data writes that follow it load the vector base and the remaining setup words.

Once setup is done, a rising edge on any line is latched. Each stage picks its winner by fixed priority, with the lowest index highest. The processor answers the combined request with a one-cycle acknowledge strobe. One cycle later the block returns an 8-bit vector, and the serviced input moves into an in-service set. Software then writes end-of-service commands to retire in-service entries. With bases 0x20 and 0x28, lines 0 to 15 map to vectors 32 to 47.

Top module: `irq_cascade_top`

## Requirements
- R1: Command addresses are 0x20 (primary) and 0xA0 (secondary). The data address of each is the command address plus 1. A command write with bit 4 set starts setup and clears that stage's latched requests, in-service set and mask. The next data write loads the base from bits 7:3. If the setup word had bit 1 clear, a cascade word follows. If it had bit 0 set, a mode word follows. After those, setup is complete.
- R2: A stage that has not completed setup never raises a request.
- R3: Requests are latched on a rising edge. A line held high after its service has ended does not request again.
- R4: The returned vector is the stage base (bits 7:3) joined to the winning input index (bits 2:0). With bases 0x20 and 0x28, line n returns 32+n.
- R5: Fixed priority applies, with input 0 highest. An unmasked pending input asserts `cpuIntr` only if its index is lower than every in-service index of its stage.
- R6: A one-cycle `intAck` is answered in the next cycle by a one-cycle `vecValid` with the vector. The winning input leaves the pending set and enters the in-service set.
- R7: The secondary request drives primary input 2 as a level. When that input wins, primary in-service bit 2 and the secondary winner's in-service bit are both set, and the secondary stage supplies the vector. Line 2 itself has no effect.
- R8: A data write outside setup loads the stage mask, where a 1 blocks an input. A request latched while masked is raised after unmasking.
- R9: A command with bits 7:5 = 001 and bits 4:3 = 00 (for example 0x20) clears the highest-priority in-service bit of that stage.
- R10: A command with bits 7:5 = 011 and bits 4:3 = 00 clears the in-service bit named by bits 2:0.
- R11: An acknowledge with no eligible request returns the primary base plus 7 and leaves every in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Write strobe of the I/O bus |
| ioAddr | input | 8 | I/O address |
| ioWrData | input | 8 | I/O write data |
| irqIn | input | 16 | Interrupt lines; bit 2 is reserved for the cascade |
| intAck | input | 1 | One-cycle acknowledge from the processor |
| cpuIntr | output | 1 | Combined interrupt request |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecOut | output | 8 | Returned vector |

## Verification
A wrong setup state shows up as a request that never rises, or as a vector with the wrong upper five bits on the first acknowledge. A corrupted in-service set shows up as a lost or extra `cpuIntr`. Because in-service bits block lower-priority requests, the stimulus places a lower-priority pending line behind each in-service entry. Each EOI form is then visible at `cpuIntr` within two cycles of the command write. Cascade errors show up as the wrong stage base in `vecOut`, or as a secondary line that stays blocked after both stages receive their end-of-service commands.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  typedef struct packed {
    logic       startInit;
    logic       loadBase;
    logic       loadMask;
    logic       eoiNonSpec;
    logic       eoiSpec;
    logic [2:0] eoiLvl;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_init_ctrl.sv
module irq_init_ctrl
  import irq_cascade_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         selCmd,
  input  logic         selData,
  input  logic [7:0]   wrData,
  output ctrlStrobes_t stb,
  output logic         initDone
);
  typedef enum logic [1:0] {ST_READY, ST_BASE, ST_CASC, ST_MODE} initState_t;
  initState_t state, nextState;
  logic needCasc, needMode;

  always_comb begin
    stb = '0;
    stb.eoiLvl = wrData[2:0];
    nextState = state;
    if (selCmd) begin
      if (wrData[4]) begin
        stb.startInit = 1'b1;
        nextState = ST_BASE;
      end else if (!wrData[3]) begin
        stb.eoiNonSpec = (wrData[7:5] == 3'b001);
        stb.eoiSpec    = (wrData[7:5] == 3'b011);
      end
    end else if (selData) begin
      unique case (state)
        ST_READY: stb.loadMask = 1'b1;
        ST_BASE: begin
          stb.loadBase = 1'b1;
          nextState = needCasc ? ST_CASC : (needMode ? ST_MODE : ST_READY);
        end
        ST_CASC: nextState = needMode ? ST_MODE : ST_READY;
        ST_MODE: nextState = ST_READY;
        default: nextState = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_READY;
      needCasc <= 1'b0;
      needMode <= 1'b0;
      initDone <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.startInit) begin
        needCasc <= !wrData[1];
        needMode <= wrData[0];
        initDone <= 1'b0;
      end else if (state != ST_READY && nextState == ST_READY) begin
        initDone <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_cascade_pkg::*;
#(
  parameter int         N_IN       = 8,
  parameter logic [7:0] LEVEL_MASK = 8'h00,
  localparam int        IW         = $clog2(N_IN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  stb,
  input  logic          initDone,
  input  logic [7:0]    wrData,
  input  logic [N_IN-1:0] reqLines,
  input  logic          ack,
  output logic          winValid,
  output logic [IW-1:0] winIdx,
  output logic [7:0]    vec,
  output logic [N_IN-1:0] isrOut
);
  logic [N_IN-1:0] reqPrev, irr, isr, mask, edges, effReq, pend;
  logic [N_IN-1:0] setIsr, clrIsr, winHot;
  logic [7-IW:0]   base;
  logic            pendHit, isrHit;
  logic [IW-1:0]   pendIdx, isrIdx;

  function automatic logic [IW:0] pickLow(input logic [N_IN-1:0] v);
    pickLow = '0;
    for (int i = N_IN - 1; i >= 0; i--)
      if (v[i]) pickLow = {1'b1, i[IW-1:0]};
  endfunction

  assign edges  = reqLines & ~reqPrev & ~LEVEL_MASK[N_IN-1:0];
  assign effReq = (irr & ~LEVEL_MASK[N_IN-1:0]) | (reqLines & LEVEL_MASK[N_IN-1:0]);
  assign pend   = effReq & ~mask;
  assign {pendHit, pendIdx} = pickLow(pend);
  assign {isrHit, isrIdx}   = pickLow(isr);

  assign winValid = initDone && pendHit && (!isrHit || pendIdx < isrIdx);
  assign winIdx   = pendIdx;
  assign winHot   = (ack && winValid) ? (N_IN'(1) << pendIdx) : '0;
  assign vec      = {base, winValid ? pendIdx : {IW{1'b1}}};
  assign isrOut   = isr;

  always_comb begin
    clrIsr = '0;
    if (stb.eoiNonSpec && isrHit) clrIsr = N_IN'(1) << isrIdx;
    else if (stb.eoiSpec)         clrIsr = N_IN'(1) << stb.eoiLvl;
    setIsr = winHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      irr     <= '0;
      isr     <= '0;
      mask    <= '0;
      base    <= '0;
    end else begin
      reqPrev <= reqLines;
      if (stb.startInit) begin
        irr  <= '0;
        isr  <= '0;
        mask <= '0;
      end else begin
        irr <= (irr | edges) & ~winHot & ~LEVEL_MASK[N_IN-1:0];
        isr <= (isr & ~clrIsr) | setIsr;
        if (stb.loadMask) mask <= wrData[N_IN-1:0];
      end
      if (stb.loadBase) base <= wrData[7:IW];
    end
  end
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter logic [7:0] PRI_PORT   = 8'h20,
  parameter logic [7:0] SEC_PORT   = 8'hA0,
  parameter int         CASCADE_IN = 2,
  localparam logic [7:0] CAS_BIT   = 8'(1) << CASCADE_IN
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioWr,
  input  logic [7:0]  ioAddr,
  input  logic [7:0]  ioWrData,
  input  logic [15:0] irqIn,
  input  logic        intAck,
  output logic        cpuIntr,
  output logic        vecValid,
  output logic [7:0]  vecOut
);
  ctrlStrobes_t stb [2];
  logic         done [2];
  logic         winValid [2];
  logic [2:0]   winIdx [2];
  logic [7:0]   vec [2];
  logic [7:0]   isr [2];
  logic [7:0]   lines [2];
  logic         ack [2];

  assign lines[0] = (irqIn[7:0] & ~CAS_BIT) | (winValid[1] ? CAS_BIT : 8'h00);
  assign lines[1] = irqIn[15:8];
  assign ack[0]   = intAck;
  assign ack[1]   = intAck && winValid[0] && (winIdx[0] == 3'(CASCADE_IN));
  assign cpuIntr  = winValid[0];

  for (genvar g = 0; g < 2; g++) begin : gStage
    localparam logic [7:0] PORT = (g == 0) ? PRI_PORT : SEC_PORT;
    irq_init_ctrl uCtrl (
      .clk(clk), .rstN(rstN),
      .selCmd(ioWr && ioAddr == PORT),
      .selData(ioWr && ioAddr == (PORT | 8'h01)),
      .wrData(ioWrData), .stb(stb[g]), .initDone(done[g])
    );
    irq_bank #(.N_IN(8), .LEVEL_MASK((g == 0) ? CAS_BIT : 8'h00)) uBank (
      .clk(clk), .rstN(rstN), .stb(stb[g]), .initDone(done[g]),
      .wrData(ioWrData), .reqLines(lines[g]), .ack(ack[g]),
      .winValid(winValid[g]), .winIdx(winIdx[g]), .vec(vec[g]), .isrOut(isr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= intAck;
      if (intAck) vecOut <= ack[1] ? vec[1] : vec[0];
    end
  end
endmodule

// File: rtl/irq_cascade_checker.sv
module irq_cascade_checker (
  input logic       clk,
  input logic       rstN,
  input logic       intAck,
  input logic       cpuIntr,
  input logic       vecValid,
  input logic       mDone,
  input logic       mEoi,
  input logic       mWinValid,
  input logic [2:0] mWinIdx,
  input logic [7:0] mIsr
);
  // R6: acknowledge answered next cycle
  assert_ack_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> vecValid);
  // R6: no vector without an acknowledge
  assert_vec_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck));
  // R6: winner enters in-service
  assert_ack_isr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && mWinValid) |=> mIsr[$past(mWinIdx)]);
  // R2: no request before setup
  assert_uninit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !mDone |-> !cpuIntr);
  // R9: non-specific EOI retires exactly one entry
  assert_eoi_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mEoi && mIsr != 8'h00 && !intAck) |=> $countones(mIsr) == $countones($past(mIsr)) - 1);
endmodule

bind irq_cascade_top irq_cascade_checker u_chk (
  .clk(clk), .rstN(rstN), .intAck(intAck), .cpuIntr(cpuIntr),
  .vecValid(vecValid), .mDone(done[0]), .mEoi(stb[0].eoiNonSpec),
  .mWinValid(winValid[0]), .mWinIdx(winIdx[0]), .mIsr(isr[0])
);

// File: tb/sim_irq_cascade_top.sv
`timescale 1ns/1ps
module sim_irq_cascade_top;
  logic clk = 1'b0, rstN = 1'b0, ioWr = 1'b0, intAck = 1'b0;
  logic [7:0] ioAddr = '0, ioWrData = '0;
  logic [15:0] irqIn = '0;
  logic cpuIntr, vecValid;
  logic [7:0] vecOut;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  irq_cascade_top u0 (.clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .irqIn(irqIn), .intAck(intAck), .cpuIntr(cpuIntr),
    .vecValid(vecValid), .vecOut(vecOut));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ioWr = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic doAck(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    idle(1);
  endtask

  task automatic intrIs(input logic exp, input string tag);
    idle(2);
    check(tag, {7'd0, cpuIntr}, {7'd0, exp});
  endtask

  task automatic initPair();
    ioWrite(8'h20, 8'h11); ioWrite(8'h21, 8'h20); ioWrite(8'h21, 8'h04); ioWrite(8'h21, 8'h01);
    ioWrite(8'hA0, 8'h11); ioWrite(8'hA1, 8'h28); ioWrite(8'hA1, 8'h02); ioWrite(8'hA1, 8'h01);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: unexpected vector actual %0h expected none", vecOut);
      end else begin
        string t;
        logic [7:0] e;
        e = expQ.pop_front(); t = tagQ.pop_front();
        check(t, vecOut, e);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rstN = 1'b1; idle(1);
    check("R6 reset vecValid", {7'd0, vecValid}, 8'd0);
    check("R2 reset cpuIntr", {7'd0, cpuIntr}, 8'd0);
    irqIn[0] = 1'b1;
    intrIs(1'b0, "R2 no request before setup");
    irqIn[0] = 1'b0;
    initPair();
    ioWrite(8'h21, 8'h00); ioWrite(8'hA1, 8'h00);
    intrIs(1'b0, "R1 setup cleared latched edge");

    irqIn[3] = 1'b1;
    intrIs(1'b1, "R3 edge latched");
    doAck(8'h23, "R4 vector line 3");
    intrIs(1'b0, "R6 request moved to in-service");
    irqIn[5] = 1'b1;
    intrIs(1'b0, "R5 blocked by in-service 3");
    irqIn[1] = 1'b1;
    intrIs(1'b1, "R5 higher priority nests");
    doAck(8'h21, "R4 vector line 1");
    ioWrite(8'h20, 8'h20);
    intrIs(1'b0, "R9 EOI cleared 1, 3 still blocks");
    ioWrite(8'h20, 8'h20);
    intrIs(1'b1, "R9 EOI cleared 3");
    doAck(8'h25, "R5 vector line 5");
    ioWrite(8'h20, 8'h20);
    intrIs(1'b0, "R3 held lines do not re-request");
    irqIn[1] = 1'b0; irqIn[3] = 1'b0; irqIn[5] = 1'b0;

    irqIn[10] = 1'b1;
    intrIs(1'b1, "R7 secondary request");
    doAck(8'h2A, "R7 vector line 10");
    intrIs(1'b0, "R7 cascade in service");
    ioWrite(8'hA0, 8'h20); ioWrite(8'h20, 8'h20);
    irqIn[10] = 1'b0;

    irqIn[9] = 1'b1; irqIn[6] = 1'b1;
    intrIs(1'b1, "R7 simultaneous requests");
    doAck(8'h29, "R7 input 2 beats input 6");
    ioWrite(8'hA0, 8'h20); ioWrite(8'h20, 8'h20);
    intrIs(1'b1, "R7 line 6 after cascade EOI");
    doAck(8'h26, "R4 vector line 6");
    ioWrite(8'h20, 8'h20);
    irqIn[9] = 1'b0; irqIn[6] = 1'b0;

    irqIn[2] = 1'b1;
    intrIs(1'b0, "R7 line 2 has no effect");
    irqIn[2] = 1'b0;

    ioWrite(8'h21, 8'h10);
    irqIn[4] = 1'b1;
    intrIs(1'b0, "R8 masked line");
    ioWrite(8'h21, 8'h00);
    intrIs(1'b1, "R8 latched request after unmask");
    doAck(8'h24, "R8 vector line 4");
    ioWrite(8'h20, 8'h20);
    irqIn[4] = 1'b0;
    ioWrite(8'hA1, 8'h01);
    irqIn[8] = 1'b1;
    intrIs(1'b0, "R8 secondary masked");
    ioWrite(8'hA1, 8'h00);
    doAck(8'h28, "R8 vector line 8");
    ioWrite(8'hA0, 8'h20); ioWrite(8'h20, 8'h20);
    irqIn[8] = 1'b0;

    irqIn[3] = 1'b1; idle(2);
    doAck(8'h23, "R10 vector line 3");
    irqIn[0] = 1'b1; idle(2);
    doAck(8'h20, "R10 vector line 0");
    irqIn[5] = 1'b1;
    ioWrite(8'h20, 8'h63);
    intrIs(1'b0, "R10 in-service 0 still blocks");
    ioWrite(8'h20, 8'h20);
    intrIs(1'b1, "R10 specific EOI removed 3");
    doAck(8'h25, "R10 vector line 5");
    ioWrite(8'h20, 8'h20);
    irqIn[0] = 1'b0; irqIn[3] = 1'b0; irqIn[5] = 1'b0;

    doAck(8'h27, "R11 spurious vector");
    intrIs(1'b0, "R11 no request after spurious");
    irqIn[7] = 1'b1;
    intrIs(1'b1, "R11 in-service 7 untouched");
    doAck(8'h27, "R4 vector line 7");
    ioWrite(8'h20, 8'h20);
    irqIn[7] = 1'b0;

    ioWrite(8'h21, 8'hFF);
    ioWrite(8'h20, 8'h11); ioWrite(8'h21, 8'h20); ioWrite(8'h21, 8'h04); ioWrite(8'h21, 8'h01);
    irqIn[0] = 1'b1;
    intrIs(1'b1, "R1 setup cleared mask");
    doAck(8'h20, "R1 base reloaded");
    ioWrite(8'h20, 8'h20);
    irqIn[0] = 1'b0;

    idle(4);
    check("R6 all vectors returned", 8'(expQ.size()), 8'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule